// File: doc/BRIEF.md
# Multi-Slave Link Master Register Controller

This block sits on the host side of a point-to-multipoint link and lets software talk to as many as four remote slaves through a small memory-mapped register set. Software loads a target address, a data word and a command word into transmit registers, then writes the control register to start the transfer. The block offers the packet on a parallel request port, waits for the reply on a parallel response port, and checks that the replying slave is the one that was asked. It then latches the reply's command/status word and, for a read, the returned data.

Progress is reported through one interrupt register that mixes two kinds of bits. Sticky event bits stay set until software writes a one to them. Level bits follow the live state of the transmit and receive buffers. A status register shows whether a link partner is present and whether the link is up. Bringing the link up takes two steps: software sets an enable bit, and the link answers with an acknowledge.

Top module: `slink_ctrl`

## Requirements
- R1: After reset, `link_en` and `req_valid` are low. Status (offset 0) reads 0x0000 when no partner is present. Control (offset 1) reads 0x0000. Interrupt (offset 2) reads 0x0400, which is only the transmit-buffer-free level.
- R2: Status bit 15 follows `link_present`. Status bit 14 (link up) becomes 1 on the first clock edge at which both the enable bit and `link_ack` are high.
- R3: A control write sets `link_en` from data bit 15. Writing 0x8001 while the link is up and idle raises `req_valid`, with `req_cmd`, `req_addr` and `req_data` taken from the command (offset 5), address (offset 3) and data (offset 4) registers. Control bit 0 reads 1 until the request is accepted (`req_valid` and `req_ready` high at an edge) and then clears by itself.
- R4: A start written while a transfer is outstanding, whether not yet accepted or waiting for its reply, has no effect.
- R5: A start written while the link is not up raises no request and sets event bit 9 (transmit error).
- R6: Acceptance of a request sets event bit 11 (packet transmitted). Level bit 10 (transmit buffer free) is 0 exactly while a request waits for acceptance.
- R7: The command word carries the slave number in bits 15:14 and the command code in bits 13:12; code 0 is a write and code 1 is a read. A reply whose bits 15:14 equal the outstanding slave ends the transfer, is stored whole in the receive command/status register (offset 6) and sets event bit 15 (packet received). If its code is 1, `rsp_data` is also stored in the receive data register (offset 7) and level bit 14 (receive content available) is set.
- R8: A reply from any other slave, or a reply when no transfer is waiting, sets event bit 13 (receive error). It changes neither receive register, and an outstanding transfer stays outstanding.
- R9: Writing the interrupt register clears each of event bits 7, 9, 11, 13 and 15 whose data bit is 1. Level bits 10 and 14 are not affected by the write. An event raised in the same cycle as its clear stays set.
- R10: When the link drops, status bit 14 clears, event bit 7 (slave link changed) is set and any outstanding transfer is abandoned.
- R11: Level bit 14 clears when a new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| link_present | input | 1 | Link partner detected |
| link_ack | input | 1 | Link-up acknowledge from the link |
| link_en | output | 1 | Link enable request |
| req_valid | output | 1 | Request packet valid |
| req_ready | input | 1 | Link accepts the request packet |
| req_cmd | output | 16 | Request command word |
| req_addr | output | 16 | Request address |
| req_data | output | 16 | Request data |
| rsp_valid | input | 1 | Reply packet valid for one cycle |
| rsp_cmd | input | 16 | Reply command/status word |
| rsp_data | input | 16 | Reply data |

## Verification
The bench sweeps every slave number with both command codes. For each pair it sends replies from all three wrong slaves before the right one. A design that matched on the command code, or on nothing at all, would then overwrite the receive registers or end the transfer early. Each wrong reply arrives in the same cycle as a clear of the receive-error bit. A design where the clear wins would lose that event. Repeated starts are issued while a request is pending and while a reply is awaited, which exposes a design that sends twice. Write-backs of the whole interrupt word show whether the level bits are wrongly treated as clearable. A link drop in the middle of a transfer followed by a late reply shows whether the abandoned transfer still accepts data.

// File: rtl/slink_pkg.sv
package slink_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 3'd0,
    RA_CTRL   = 3'd1,
    RA_INT    = 3'd2,
    RA_TXADDR = 3'd3,
    RA_TXDATA = 3'd4,
    RA_TXCMD  = 3'd5,
    RA_RXCS   = 3'd6,
    RA_RXDATA = 3'd7
  } reg_addr_e;

  // interrupt word bit positions
  localparam int unsigned IB_LINK_CHG = 7;
  localparam int unsigned IB_TX_ERR   = 9;
  localparam int unsigned IB_TX_FREE  = 10;
  localparam int unsigned IB_TX_DONE  = 11;
  localparam int unsigned IB_RX_ERR   = 13;
  localparam int unsigned IB_RX_AVAIL = 14;
  localparam int unsigned IB_RX_PKT   = 15;

  // status and control bit positions
  localparam int unsigned SB_PRESENT = 15;
  localparam int unsigned SB_UP      = 14;
  localparam int unsigned CB_ENABLE  = 15;
  localparam int unsigned CB_START   = 0;

  localparam logic [15:0] EV_MASK = (16'h1 << IB_LINK_CHG) | (16'h1 << IB_TX_ERR)
                                  | (16'h1 << IB_TX_DONE)  | (16'h1 << IB_RX_ERR)
                                  | (16'h1 << IB_RX_PKT);

  localparam int unsigned CODE_W  = 2;
  localparam int unsigned CODE_RD = 1;
endpackage

// File: rtl/slink_link_mon.sv
module slink_link_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic link_en,
  input  logic link_ack,
  output logic link_up,
  output logic link_fell
);
  logic up_d;
  logic up_q;

  always_comb begin
    up_d = link_en & link_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= up_d;
  end

  assign link_up   = up_q;
  assign link_fell = up_q & ~up_d;
endmodule

// File: rtl/slink_tx_seq.sv
module slink_tx_seq #(
  parameter int unsigned SLV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic             link_up,
  input  logic             link_fell,
  input  logic             req_ready,
  input  logic             rsp_done,
  input  logic [SLV_W-1:0] tx_slave,
  output logic             req_valid,
  output logic             awaiting,
  output logic             start_acc,
  output logic             start_rej,
  output logic             sent,
  output logic [SLV_W-1:0] exp_slave
);
  logic             pend_q, pend_d;
  logic             wait_q, wait_d;
  logic [SLV_W-1:0] slv_q;
  logic             busy;
  logic             abort;

  always_comb begin
    busy      = pend_q | wait_q;
    abort     = stop_wr | link_fell;
    start_acc = start_wr & link_up & ~link_fell & ~busy;
    start_rej = start_wr & (~link_up | link_fell);
    sent      = pend_q & req_ready;

    pend_d = pend_q;
    wait_d = wait_q;
    if (sent) begin
      pend_d = 1'b0;
      wait_d = 1'b1;
    end
    if (rsp_done)  wait_d = 1'b0;
    if (start_acc) pend_d = 1'b1;
    if (abort) begin
      pend_d = 1'b0;
      wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slv_q <= '0;
    else if (start_acc) slv_q <= tx_slave;
  end

  assign req_valid = pend_q;
  assign awaiting  = wait_q;
  assign exp_slave = slv_q;
endmodule

// File: rtl/slink_rx_chk.sv
module slink_rx_chk
  import slink_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_cmd,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              awaiting,
  input  logic [SLV_W-1:0]  exp_slave,
  input  logic              new_xfer,
  output logic [DATA_W-1:0] rx_cs,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              rsp_done,
  output logic              rx_bad
);
  localparam int unsigned SLV_HI  = DATA_W - 1;
  localparam int unsigned CODE_HI = DATA_W - 1 - SLV_W;

  logic [SLV_W-1:0]  rsp_slv;
  logic [CODE_W-1:0] rsp_code;
  logic              hit;
  logic              cs_en;
  logic              data_en;
  logic              avail_d, avail_q;
  logic [DATA_W-1:0] cs_q, data_q;

  always_comb begin
    rsp_slv  = rsp_cmd[SLV_HI -: SLV_W];
    rsp_code = rsp_cmd[CODE_HI -: CODE_W];
    hit      = rsp_valid & awaiting & (rsp_slv == exp_slave);
    rx_bad   = rsp_valid & ~hit;
    cs_en    = hit;
    data_en  = hit & (rsp_code == CODE_W'(CODE_RD));
    avail_d  = avail_q;
    if (data_en)  avail_d = 1'b1;
    if (new_xfer) avail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= 1'b0;
    else        avail_q <= avail_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_q <= '0;
    else if (cs_en) cs_q <= rsp_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= rsp_data;
  end

  assign rx_cs    = cs_q;
  assign rx_data  = data_q;
  assign rx_avail = avail_q;
  assign rsp_done = hit;
endmodule

// File: rtl/slink_irq.sv
module slink_irq
  import slink_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] clr_data,
  input  logic [DATA_W-1:0] lvl_vec,
  output logic [DATA_W-1:0] ev_q,
  output logic [DATA_W-1:0] int_word
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(EV_MASK);

  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] ev_d;

  always_comb begin
    clr_vec  = clr_wr ? (clr_data & MASK) : '0;
    ev_d     = (ev_q & ~clr_vec) | (set_vec & MASK);
    int_word = ev_q | (lvl_vec & ~MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end
endmodule

// File: rtl/slink_ctrl.sv
module slink_ctrl
  import slink_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SLAVE_CNT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [REG_AW-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     link_present,
  input  logic                     link_ack,
  output logic                     link_en,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [DATA_W-1:0]        req_cmd,
  output logic [DATA_W-1:0]        req_addr,
  output logic [DATA_W-1:0]        req_data,
  input  logic                     rsp_valid,
  input  logic [DATA_W-1:0]        rsp_cmd,
  input  logic [DATA_W-1:0]        rsp_data
);
  localparam int unsigned SLV_W = (SLAVE_CNT > 1) ? $clog2(SLAVE_CNT) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // register write decode
  logic wr_ctrl, wr_int, wr_txaddr, wr_txdata, wr_txcmd;
  logic start_wr, stop_wr;

  always_comb begin
    wr_ctrl   = bus_wr & (bus_addr == RA_CTRL);
    wr_int    = bus_wr & (bus_addr == RA_INT);
    wr_txaddr = bus_wr & (bus_addr == RA_TXADDR);
    wr_txdata = bus_wr & (bus_addr == RA_TXDATA);
    wr_txcmd  = bus_wr & (bus_addr == RA_TXCMD);
    start_wr  = wr_ctrl & bus_wdata[CB_ENABLE] & bus_wdata[CB_START];
    stop_wr   = wr_ctrl & ~bus_wdata[CB_ENABLE];
  end

  // host-written registers
  logic              en_q;
  logic [DATA_W-1:0] txaddr_q, txdata_q, txcmd_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     en_q <= 1'b0;
    else if (wr_ctrl) en_q <= bus_wdata[CB_ENABLE];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)       txaddr_q <= '0;
    else if (wr_txaddr) txaddr_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)       txdata_q <= '0;
    else if (wr_txdata) txdata_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      txcmd_q <= '0;
    else if (wr_txcmd) txcmd_q <= bus_wdata;
  end

  // link state
  logic link_up, link_fell;

  slink_link_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .link_en   (en_q),
    .link_ack  (link_ack),
    .link_up   (link_up),
    .link_fell (link_fell)
  );

  // transfer sequencing
  logic             awaiting, start_acc, start_rej, sent, rsp_done;
  logic [SLV_W-1:0] exp_slave;

  slink_tx_seq #(.SLV_W(SLV_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_wr  (start_wr),
    .stop_wr   (stop_wr),
    .link_up   (link_up),
    .link_fell (link_fell),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .tx_slave  (txcmd_q[DATA_W-1 -: SLV_W]),
    .req_valid (req_valid),
    .awaiting  (awaiting),
    .start_acc (start_acc),
    .start_rej (start_rej),
    .sent      (sent),
    .exp_slave (exp_slave)
  );

  // reply checking
  logic [DATA_W-1:0] rx_cs, rx_data;
  logic              rx_avail, rx_bad;

  slink_rx_chk #(.DATA_W(DATA_W), .SLV_W(SLV_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rsp_valid (rsp_valid),
    .rsp_cmd   (rsp_cmd),
    .rsp_data  (rsp_data),
    .awaiting  (awaiting),
    .exp_slave (exp_slave),
    .new_xfer  (start_acc),
    .rx_cs     (rx_cs),
    .rx_data   (rx_data),
    .rx_avail  (rx_avail),
    .rsp_done  (rsp_done),
    .rx_bad    (rx_bad)
  );

  // interrupt register
  logic [DATA_W-1:0] set_vec, lvl_vec, int_ev, int_word;

  always_comb begin
    set_vec              = '0;
    set_vec[IB_LINK_CHG] = link_fell;
    set_vec[IB_TX_ERR]   = start_rej;
    set_vec[IB_TX_DONE]  = sent;
    set_vec[IB_RX_ERR]   = rx_bad;
    set_vec[IB_RX_PKT]   = rsp_done;
    lvl_vec              = '0;
    lvl_vec[IB_TX_FREE]  = ~req_valid;
    lvl_vec[IB_RX_AVAIL] = rx_avail;
  end

  slink_irq #(.DATA_W(DATA_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set_vec  (set_vec),
    .clr_wr   (wr_int),
    .clr_data (bus_wdata),
    .lvl_vec  (lvl_vec),
    .ev_q     (int_ev),
    .int_word (int_word)
  );

  // read mux
  logic [DATA_W-1:0] status_word, ctrl_word;

  always_comb begin
    status_word             = '0;
    status_word[SB_PRESENT] = link_present;
    status_word[SB_UP]      = link_up;
    ctrl_word               = '0;
    ctrl_word[CB_ENABLE]    = en_q;
    ctrl_word[CB_START]     = req_valid;
    case (bus_addr)
      RA_STATUS: bus_rdata = status_word;
      RA_CTRL:   bus_rdata = ctrl_word;
      RA_INT:    bus_rdata = int_word;
      RA_TXADDR: bus_rdata = txaddr_q;
      RA_TXDATA: bus_rdata = txdata_q;
      RA_TXCMD:  bus_rdata = txcmd_q;
      RA_RXCS:   bus_rdata = rx_cs;
      default:   bus_rdata = rx_data;
    endcase
  end

  assign link_en  = en_q;
  assign req_cmd  = txcmd_q;
  assign req_addr = txaddr_q;
  assign req_data = txdata_q;
endmodule

// File: rtl/slink_ctrl_chk.sv
module slink_ctrl_chk
  import slink_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SLV_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              link_en,
  input logic              link_up,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_cmd,
  input logic              awaiting,
  input logic [SLV_W-1:0]  exp_slave,
  input logic [DATA_W-1:0] rx_cs,
  input logic [DATA_W-1:0] int_ev
);
  // R3: an offered request stays offered until taken, unless the link goes away
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || !link_en || !link_up));

  // R3: start self-clears once the link takes the packet
  p_start_selfclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R5: no request is ever offered on a link that is not up
  p_req_needs_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (link_en && link_up));

  // R6: acceptance is always followed by the transmitted event
  p_tx_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> int_ev[IB_TX_DONE]);

  // R8: foreign or unsolicited replies flag an error and leave the register alone
  p_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (!awaiting || rsp_cmd[DATA_W-1 -: SLV_W] != exp_slave))
      |=> (int_ev[IB_RX_ERR] && $stable(rx_cs)));

  // R10: a dropped link raises the link-changed event
  p_link_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |-> int_ev[IB_LINK_CHG]);

  // R10: a dropped link leaves nothing outstanding
  p_link_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |-> (!req_valid && !awaiting));
endmodule

bind slink_ctrl slink_ctrl_chk #(.DATA_W(DATA_W), .SLV_W(SLV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .link_en   (link_en),
  .link_up   (link_up),
  .rsp_valid (rsp_valid),
  .rsp_cmd   (rsp_cmd),
  .awaiting  (awaiting),
  .exp_slave (exp_slave),
  .rx_cs     (rx_cs),
  .int_ev    (int_ev)
);

// File: tb/tb_slink_ctrl.sv
module tb_slink_ctrl;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        link_present, link_ack, link_en;
  logic        req_valid, req_ready;
  logic [15:0] req_cmd, req_addr, req_data;
  logic        rsp_valid;
  logic [15:0] rsp_cmd, rsp_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_cs = 16'h0;
  logic [15:0] exp_rd = 16'h0;

  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_INT = 3'd2, A_TXA = 3'd3,
                         A_TXD = 3'd4, A_TXC = 3'd5, A_RXCS = 3'd6, A_RXD = 3'd7;

  slink_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_present(link_present),
    .link_ack(link_ack), .link_en(link_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd),
    .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic reply(input logic [15:0] c, input logic [15:0] d, input logic clr13);
    rsp_valid = 1'b1; rsp_cmd = c; rsp_data = d;
    if (clr13) begin
      bus_wr = 1'b1; bus_addr = A_INT; bus_wdata = 16'h2000;
    end
    step();
    rsp_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic accept();
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    link_present = 0; link_ack = 0; req_ready = 0;
    rsp_valid = 0; rsp_cmd = 0; rsp_data = 0;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();

    // R1 reset state
    chk("R1 link_en", {15'h0, link_en}, 16'h0);
    chk("R1 req_valid", {15'h0, req_valid}, 16'h0);
    chk_reg("R1 status", A_STAT, 16'h0000);
    chk_reg("R1 control", A_CTRL, 16'h0000);
    chk_reg("R1 interrupt", A_INT, 16'h0400);

    // R2 presence
    link_present = 1;
    chk_reg("R2 present", A_STAT, 16'h8000);

    // R5 start with link not up
    wr(A_CTRL, 16'h8001);
    chk("R5 no request", {15'h0, req_valid}, 16'h0);
    chk("R3 link_en", {15'h0, link_en}, 16'h1);
    chk_reg("R5 tx error", A_INT, 16'h0600);
    wr(A_INT, 16'h0200);
    chk_reg("R9 clear tx error", A_INT, 16'h0400);
    chk_reg("R2 not up without ack", A_STAT, 16'h8000);

    // R2 link up
    link_ack = 1;
    step();
    chk_reg("R2 link up", A_STAT, 16'hC000);

    // sweep slaves and command codes
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        logic [15:0] a, d, cmd, rc, rdat;
        logic [15:0] avail;
        a    = 16'h1000 + 16'(s * 16 + c);
        d    = 16'hA5C3 ^ 16'(s << 4) ^ 16'(c);
        cmd  = 16'(s << 14) | 16'(c << 12) | 16'(c);
        wr(A_TXA, a);
        wr(A_TXD, d);
        wr(A_TXC, cmd);
        wr(A_CTRL, 16'h8001);
        chk("R3 req_valid", {15'h0, req_valid}, 16'h1);
        chk("R3 req_cmd", req_cmd, cmd);
        chk("R3 req_addr", req_addr, a);
        chk("R3 req_data", req_data, d);
        chk_reg("R3 start pending", A_CTRL, 16'h8001);
        chk_reg("R6 R11 buffer busy, avail cleared", A_INT, 16'h0000);
        // R4 repeated start while pending
        wr(A_CTRL, 16'h8001);
        chk_reg("R4 start while pending", A_INT, 16'h0000);
        accept();
        chk("R3 self-clear", {15'h0, req_valid}, 16'h0);
        chk_reg("R3 control after accept", A_CTRL, 16'h8000);
        chk_reg("R6 transmitted", A_INT, 16'h0C00);
        // R4 start while awaiting reply
        wr(A_CTRL, 16'h8001);
        chk("R4 start while awaiting", {15'h0, req_valid}, 16'h0);
        // R8 replies from other slaves, R9 set beats clear
        for (int o = 0; o < 4; o++) begin
          if (o != s) begin
            reply(16'(o << 14) | 16'(c << 12), 16'hDEAD, 1'b1);
            chk_reg("R8 R9 rx error kept", A_INT, 16'h2C00);
            chk_reg("R8 rxcs unchanged", A_RXCS, exp_cs);
            chk_reg("R8 rxdata unchanged", A_RXD, exp_rd);
          end
        end
        wr(A_INT, 16'h2000);
        chk_reg("R9 clear rx error", A_INT, 16'h0C00);
        // R7 matching reply
        rc   = 16'(s << 14) | 16'(c << 12) | 16'(s * 3 + 5);
        rdat = ~d;
        reply(rc, rdat, 1'b0);
        exp_cs = rc;
        if (c == 1) exp_rd = rdat;
        avail = (c == 1) ? 16'h4000 : 16'h0000;
        chk_reg("R7 rxcs", A_RXCS, exp_cs);
        chk_reg("R7 rxdata", A_RXD, exp_rd);
        chk_reg("R7 received", A_INT, 16'h8C00 | avail);
        rd(A_INT, v);
        wr(A_INT, v);
        chk_reg("R9 writeback keeps levels", A_INT, 16'h0400 | avail);
      end
    end

    // R10 link drop during a transfer
    wr(A_TXC, 16'h9001);
    wr(A_CTRL, 16'h8001);
    chk_reg("R11 avail cleared on start", A_INT, 16'h0000);
    accept();
    link_ack = 0;
    step();
    chk_reg("R10 link down status", A_STAT, 16'h8000);
    chk_reg("R10 link changed event", A_INT, 16'h0C80);
    link_ack = 1;
    step();
    chk_reg("R2 link back up", A_STAT, 16'hC000);
    reply(16'h9000, 16'h1234, 1'b0);
    chk_reg("R10 abandoned reply is error", A_INT, 16'h2C80);
    chk_reg("R10 rxcs unchanged", A_RXCS, exp_cs);
    chk_reg("R10 rxdata unchanged", A_RXD, exp_rd);

    // R3 disable link
    wr(A_CTRL, 16'h0000);
    chk("R3 link_en cleared", {15'h0, link_en}, 16'h0);
    step();
    chk_reg("R10 disable drops link", A_STAT, 16'h8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule